// File: doc/BRIEF.md
# Pulse-Position Downlink Command Framer

This block assembles a downlink command for a low-frequency contactless tag and hands it, one 2-bit symbol at a time, to a pulse-position modulator that turns each symbol value into a gap position. A single start strobe captures the whole command: its kind (reset, read or write), a page or test-mode choice, an optional 32-bit password, a lock bit, 32 bits of data and a 3-bit block address. The framer flattens these into one bit sequence. It then streams that sequence two bits per symbol over a valid/ready interface.

The fields are packed back to back without regard for field edges. As a result, a symbol can straddle two fields: the lock bit rides with the top data bit, and the bottom data bit rides with the top address bit. After a write, the block keeps its field-on request high for a programming window whose length is fixed by parameters and counted in clock cycles. It then pulses done. Reads and resets finish as soon as their last symbol is taken.

Top module: `ppd_framer`

## Requirements
- R1: During and after reset, `sym_valid`, `field_on` and `done` are low.
- R2: Every frame begins with a reference symbol 00. Next comes an opcode symbol: 00 for a reset command, 01 when `test_mode` is high, and otherwise {1, `page_sel`}.
- R3: For reads and writes with `pwd_en` high, the opcode is followed by a 00 symbol and then the password, most significant bit first, two bits per symbol (16 symbols).
- R4: A write sends the bit sequence lock, data[31:0], addr[2:0], packed in order two bits per symbol with the earlier bit in symbol bit 1. The lock bit therefore shares a symbol with data[31], data[0] shares a symbol with addr[2], and the last symbol is {addr[1], addr[0]}. A write without password is 20 symbols.
- R5: A write with password is 37 symbols: reference, opcode, 00, 16 password symbols, then the 18 write symbols.
- R6: A read (`cmd`=01) sends, after the opcode and any password section, the symbols {0, addr[2]} and {addr[1], addr[0]}. This gives 4 symbols without password and 21 with.
- R7: A reset command (`cmd`=00, and also the unused code 11) is exactly two symbols, 00 then 00, whatever `pwd_en`, `page_sel` and `test_mode` are.
- R8: While `sym_valid` is high and `sym_ready` is low, `sym_valid` stays high and `sym_data` holds its value in the next cycle.
- R9: After the last write symbol is accepted, `field_on` stays high for exactly PROG_US·CLK_HZ/10^6 cycles in normal mode, or TEST_PROG_US·CLK_HZ/10^6 cycles when the write was started in test mode, and then drops.
- R10: `done` is a one-cycle pulse in the first cycle `field_on` is low after a command. For reads and resets, that is the cycle right after the last symbol is accepted.
- R11: A start strobe while `field_on` is high is ignored: no symbol is produced for it and the running command ends on schedule.
- R12: A start accepted while idle raises `field_on` and `sym_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Capture the command inputs and begin a frame when idle |
| cmd | input | 2 | Command kind: 00 reset, 01 read, 10 write, 11 treated as reset |
| page_sel | input | 1 | Page selector carried in the opcode symbol |
| test_mode | input | 1 | Use test opcode 01 and the short programming window |
| pwd_en | input | 1 | Insert the password section |
| pwd | input | 32 | Password |
| lock_bit | input | 1 | Lock bit sent ahead of write data |
| wr_data | input | 32 | Data word for writes |
| blk_addr | input | 3 | Block address |
| sym_valid | output | 1 | A symbol is presented on `sym_data` |
| sym_ready | input | 1 | Modulator accepts the presented symbol |
| sym_data | output | 2 | Current symbol, first-sent bit in bit 1 |
| field_on | output | 1 | Field request, high from start until the command completes |
| done | output | 1 | One-cycle pulse at command completion |

## Verification
The hardest situation to reach is a start strobe that lands inside the programming window of a write. By then the symbol stream has drained, so a wrongly accepted command would show up only as extra symbols or a shifted end of the window. The stimulus pulses start with a read command partway through that window. The monitor treats any symbol arriving with an empty expectation queue as an error, and the window length is measured cycle by cycle. Straddling symbols are checked by running frames whose data ends and address begins with opposite bit values. A pseudo-random ready pattern forces stalls on those exact symbols.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

  localparam int SYM_W  = 2;
  localparam int PWD_W  = 32;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  // frame sections, all in bits
  localparam int HEAD_W  = 2 * SYM_W;           // reference + opcode
  localparam int PSEC_W  = SYM_W + PWD_W;       // 00 + password
  localparam int BODY_W  = 1 + DATA_W + ADDR_W; // lock + data + address
  localparam int FRAME_W = HEAD_W + PSEC_W + BODY_W;
  localparam int MAX_SYMS = (FRAME_W + SYM_W - 1) / SYM_W;
  localparam int SCNT_W   = $clog2(MAX_SYMS + 1);

  typedef enum logic [1:0] {
    CMD_RESET = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_SPARE = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SEND = 2'b01,
    ST_PROG = 2'b10
  } state_e;

endpackage

// File: rtl/ppd_frame_compose.sv
module ppd_frame_compose
  import ppd_pkg::*;
#(
  parameter int PW  = PWD_W,
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int FW  = FRAME_W,
  parameter int CW  = SCNT_W
) (
  input  logic [1:0]    cmd,
  input  logic          page_sel,
  input  logic          test_mode,
  input  logic          pwd_en,
  input  logic [PW-1:0] pwd,
  input  logic          lock_bit,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] blk_addr,
  output logic [FW-1:0] frame,
  output logic [CW-1:0] nsym
);

  localparam int PS_W    = 2 + PW;
  localparam int BD_W    = 1 + DW + AW;
  localparam int PS_SYMS = PS_W / 2;
  localparam int WR_SYMS = (BD_W + 1) / 2;
  localparam int RD_SYMS = (AW + 2) / 2;
  localparam int TAIL_W  = FW - 4;

  cmd_e          kind;
  logic [1:0]    opcode;
  logic [3:0]    head;
  logic [PS_W-1:0] psec;
  logic [BD_W-1:0] body;
  int unsigned   body_syms;

  assign kind = cmd_e'(cmd);

  always_comb begin
    if (kind == CMD_RESET || kind == CMD_SPARE) begin
      opcode = 2'b00;
    end else if (test_mode) begin
      opcode = 2'b01;
    end else begin
      opcode = {1'b1, page_sel};
    end
    head = {2'b00, opcode};
    psec = {2'b00, pwd};
  end

  always_comb begin
    body      = '0;
    body_syms = 0;
    case (kind)
      CMD_WRITE: begin
        body      = {lock_bit, wr_data, blk_addr};
        body_syms = WR_SYMS;
      end
      CMD_READ: begin
        body      = {1'b0, blk_addr, {DW{1'b0}}};
        body_syms = RD_SYMS;
      end
      default: begin
        body      = '0;
        body_syms = 0;
      end
    endcase
  end

  always_comb begin
    if (kind == CMD_RESET || kind == CMD_SPARE) begin
      frame = {head, {TAIL_W{1'b0}}};
      nsym  = CW'(2);
    end else if (pwd_en) begin
      frame = {head, psec, body};
      nsym  = CW'(2 + PS_SYMS + body_syms);
    end else begin
      frame = {head, body, {PS_W{1'b0}}};
      nsym  = CW'(2 + body_syms);
    end
  end

endmodule

// File: rtl/ppd_sym_shift.sv
module ppd_sym_shift #(
  parameter int FW = 74,
  parameter int SW = 2,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] frame_in,
  input  logic [CW-1:0] nsym_in,
  input  logic          ready,
  output logic          valid,
  output logic [SW-1:0] data,
  output logic          last_take
);

  logic [FW-1:0] sreg_q, sreg_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          take;
  logic          upd_en;

  assign valid     = (rem_q != '0);
  assign take      = valid & ready;
  assign last_take = take & (rem_q == CW'(1));
  assign data      = sreg_q[FW-1 -: SW];
  assign upd_en    = load | take;

  always_comb begin
    sreg_d = sreg_q;
    rem_d  = rem_q;
    if (load) begin
      sreg_d = frame_in;
      rem_d  = nsym_in;
    end else if (take) begin
      sreg_d = sreg_q << SW;
      rem_d  = rem_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      rem_q  <= '0;
    end else if (upd_en) begin
      sreg_q <= sreg_d;
      rem_q  <= rem_d;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));

  // R11
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid);

endmodule

// File: rtl/ppd_window_timer.sv
module ppd_window_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire = (cnt_q == TW'(1));
  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9
  timer_free_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0));

endmodule

// File: rtl/ppd_framer.sv
module ppd_framer
  import ppd_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int PROG_US      = 20_000,
  parameter int TEST_PROG_US = 5_184
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cmd,
  input  logic              page_sel,
  input  logic              test_mode,
  input  logic              pwd_en,
  input  logic [PWD_W-1:0]  pwd,
  input  logic              lock_bit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] blk_addr,
  output logic              sym_valid,
  input  logic              sym_ready,
  output logic [SYM_W-1:0]  sym_data,
  output logic              field_on,
  output logic              done
);

  localparam longint NORM_RAW = (longint'(PROG_US) * longint'(CLK_HZ)) / 64'd1_000_000;
  localparam longint TEST_RAW = (longint'(TEST_PROG_US) * longint'(CLK_HZ)) / 64'd1_000_000;
  localparam longint NORM_CYC = (NORM_RAW < 1) ? 64'd1 : NORM_RAW;
  localparam longint TEST_CYC = (TEST_RAW < 1) ? 64'd1 : TEST_RAW;
  localparam longint MAX_CYC  = (NORM_CYC > TEST_CYC) ? NORM_CYC : TEST_CYC;
  localparam int     TMR_W    = $clog2(MAX_CYC + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // frame assembly
  logic [FRAME_W-1:0] frame;
  logic [SCNT_W-1:0]  nsym;

  ppd_frame_compose #(
    .PW (PWD_W),
    .DW (DATA_W),
    .AW (ADDR_W),
    .FW (FRAME_W),
    .CW (SCNT_W)
  ) u_compose (
    .cmd       (cmd),
    .page_sel  (page_sel),
    .test_mode (test_mode),
    .pwd_en    (pwd_en),
    .pwd       (pwd),
    .lock_bit  (lock_bit),
    .wr_data   (wr_data),
    .blk_addr  (blk_addr),
    .frame     (frame),
    .nsym      (nsym)
  );

  // control
  state_e state_q, state_d;
  logic   done_q, done_d;
  logic   wr_q, test_q;
  logic   cap_en;
  logic   ser_load;
  logic   last_take;
  logic   tmr_load;
  logic   tmr_expire;
  logic [TMR_W-1:0] tmr_val;

  assign tmr_val = test_q ? TMR_W'(TEST_CYC) : TMR_W'(NORM_CYC);

  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    ser_load = 1'b0;
    tmr_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          ser_load = 1'b1;
          state_d  = ST_SEND;
        end
      end
      ST_SEND: begin
        if (last_take) begin
          if (wr_q) begin
            tmr_load = 1'b1;
            state_d  = ST_PROG;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_PROG: begin
        if (tmr_expire) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cap_en = ser_load;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_q   <= 1'b0;
      test_q <= 1'b0;
    end else if (cap_en) begin
      wr_q   <= (cmd_e'(cmd) == CMD_WRITE);
      test_q <= test_mode;
    end
  end

  ppd_sym_shift #(
    .FW (FRAME_W),
    .SW (SYM_W),
    .CW (SCNT_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (ser_load),
    .frame_in  (frame),
    .nsym_in   (nsym),
    .ready     (sym_ready),
    .valid     (sym_valid),
    .data      (sym_data),
    .last_take (last_take)
  );

  ppd_window_timer #(
    .TW (TMR_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  assign field_on = (state_q != ST_IDLE);
  assign done     = done_q;

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);

  // R10
  fall_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(field_on) |-> done);

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_PROG && start) |=> !sym_valid);

  // R12
  start_raises_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_IDLE && start) |=> (field_on && sym_valid));

endmodule

// File: tb/test_ppd_framer.sv
module test_ppd_framer;

  localparam int CLK_HZ   = 1_000_000;
  localparam int NORM_WIN = 20_000;
  localparam int TEST_WIN = 5_184;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  cmd;
  logic        page_sel, test_mode, pwd_en, lock_bit;
  logic [31:0] pwd, wr_data;
  logic [2:0]  blk_addr;
  logic        sym_valid, sym_ready, field_on, done;
  logic [1:0]  sym_data;

  int n_checks = 0;
  int n_fail   = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  logic        rnd_ready = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        hold_prev = 1'b0;
  logic [1:0]  hold_data = 2'b00;
  logic        mon_en = 1'b0;

  always #5 clk = ~clk;

  ppd_framer #(
    .CLK_HZ       (CLK_HZ),
    .PROG_US      (20_000),
    .TEST_PROG_US (5_184)
  ) i_ppd_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd       (cmd),
    .page_sel  (page_sel),
    .test_mode (test_mode),
    .pwd_en    (pwd_en),
    .pwd       (pwd),
    .lock_bit  (lock_bit),
    .wr_data   (wr_data),
    .blk_addr  (blk_addr),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .sym_data  (sym_data),
    .field_on  (field_on),
    .done      (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sym_ready = rnd_ready ? lfsr[0] : 1'b1;
  end

  // monitor: scoreboard pop and hold check, sampled on falling edges
  always @(negedge clk) begin
    if (mon_en) begin
      if (hold_prev) begin
        chk(sym_valid && (sym_data == hold_data), "R8", "stalled symbol changed",
            int'({sym_valid, sym_data}), int'({1'b1, hold_data}));
      end
      hold_prev = sym_valid && !sym_ready;
      hold_data = sym_data;
      if (sym_valid && sym_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11", "symbol with nothing expected", int'(sym_data), -1);
        end else begin
          logic [1:0] e;
          string      t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(sym_data == e, t, "symbol value", int'(sym_data), int'(e));
        end
      end
    end
  end

  // expected symbols derived from the requirement text
  task automatic expect_frame(input logic [1:0] c, input logic pg, input logic tm,
                              input logic pe, input logic [31:0] pw, input logic lk,
                              input logic [31:0] dt, input logic [2:0] ad,
                              input string body_tag);
    bit b[$];
    bit is_rst;
    is_rst = (c == 2'b00) || (c == 2'b11);
    b.push_back(1'b0); b.push_back(1'b0);
    if (is_rst)  begin b.push_back(1'b0); b.push_back(1'b0); end
    else if (tm) begin b.push_back(1'b0); b.push_back(1'b1); end
    else         begin b.push_back(1'b1); b.push_back(pg);   end
    if (!is_rst) begin
      if (pe) begin
        b.push_back(1'b0); b.push_back(1'b0);
        for (int i = 31; i >= 0; i--) b.push_back(pw[i]);
      end
      if (c == 2'b10) begin
        b.push_back(lk);
        for (int i = 31; i >= 0; i--) b.push_back(dt[i]);
      end else begin
        b.push_back(1'b0);
      end
      for (int i = 2; i >= 0; i--) b.push_back(ad[i]);
    end
    for (int i = 0; i < b.size(); i += 2) begin
      exp_q.push_back({b[i], b[i+1]});
      if (is_rst)              tag_q.push_back("R7");
      else if (i < 4)          tag_q.push_back("R2");
      else if (pe && i < 38)   tag_q.push_back("R3");
      else                     tag_q.push_back(body_tag);
    end
  endtask

  task automatic run_cmd(input logic [1:0] c, input logic pg, input logic tm,
                         input logic pe, input logic [31:0] pw, input logic lk,
                         input logic [31:0] dt, input logic [2:0] ad,
                         input string body_tag, input int win, input bit poke);
    int cnt;
    expect_frame(c, pg, tm, pe, pw, lk, dt, ad, body_tag);
    @(negedge clk);
    cmd = c; page_sel = pg; test_mode = tm; pwd_en = pe;
    pwd = pw; lock_bit = lk; wr_data = dt; blk_addr = ad;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(field_on && sym_valid, "R12", "field_on/valid after start",
        int'({field_on, sym_valid}), 3);
    while (exp_q.size() != 0) @(posedge clk);
    // this edge takes the last symbol
    cnt = 0;
    forever begin
      @(negedge clk);
      if (cnt == 0)
        chk(!sym_valid, body_tag, "frame longer than expected", int'(sym_valid), 0);
      if (poke && cnt == 50) begin
        cmd = 2'b01; pwd_en = 1'b0; start = 1'b1;
      end
      if (poke && cnt == 51) start = 1'b0;
      if (!field_on) break;
      chk(!done, "R10", "done while field_on", int'(done), 0);
      cnt++;
    end
    chk(cnt == win, "R9", "programming window cycles", cnt, win);
    chk(done, "R10", "done at field_on fall", int'(done), 1);
    @(negedge clk);
    chk(!done, "R10", "done longer than one cycle", int'(done), 0);
    repeat (3) begin
      @(negedge clk);
      chk(!sym_valid && !field_on, "R11", "activity after completion",
          int'({field_on, sym_valid}), 0);
    end
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cmd = 2'b00; page_sel = 1'b0; test_mode = 1'b0;
    pwd_en = 1'b0; pwd = '0; lock_bit = 1'b0; wr_data = '0; blk_addr = '0;
    sym_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sym_valid && !field_on && !done, "R1", "outputs in reset",
        int'({sym_valid, field_on, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sym_valid && !field_on && !done, "R1", "outputs after reset",
        int'({sym_valid, field_on, done}), 0);
    mon_en = 1'b1;

    // R4: plain write, page 0, ready always high, start poked during window (R11)
    run_cmd(2'b10, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 32'hA5C3_0F96, 3'b101, "R4", NORM_WIN, 1'b1);

    // R7: reset command ignores password, page and test selections
    run_cmd(2'b00, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0, 3'b111, "R7", 0, 1'b0);
    run_cmd(2'b11, 1'b1, 1'b0, 1'b1, 32'h1234_5678, 1'b0, 32'h0, 3'b010, "R7", 0, 1'b0);

    // R6: plain read page 1 with stalls
    rnd_ready = 1'b1;
    run_cmd(2'b01, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 3'b110, "R6", 0, 1'b0);
    // R6 with password section (R3)
    run_cmd(2'b01, 1'b0, 1'b0, 1'b1, 32'h1234_5678, 1'b0, 32'h0, 3'b011, "R6", 0, 1'b0);

    // R5: password write in test mode, short window, stalls
    run_cmd(2'b10, 1'b0, 1'b1, 1'b1, 32'hC0DE_5A17, 1'b0, 32'hFFFF_0001, 3'b011, "R5", TEST_WIN, 1'b1);
    // R5: password write in normal mode, page 1, data LSB 0 against address MSB 1
    run_cmd(2'b10, 1'b1, 1'b0, 1'b1, 32'h8000_0001, 1'b1, 32'h7FFF_FFFE, 3'b100, "R5", NORM_WIN, 1'b0);

    summary();
  end

endmodule